// File: doc/BRIEF.md
# Packed Lane Compare and Min/Max Unit

This block is a purely combinational execution unit for a 64-bit datapath. It takes two operands and treats them as a set of independent lanes. Each lane is 8, 16, 32 or 64 bits wide, and the width is chosen on every evaluation by a small thermometer-coded control. Within each lane the unit either produces a mask that says whether the first operand is below the second, or orders the two lane values so that one output carries the minimum and the other the maximum.

A single flag selects two's-complement or unsigned interpretation. The sign of a value is the top bit of its own lane. The datapath is built from 8-bit segment comparators and a shallow segmented combining tree, so that the logic depth stays small. It has no clock and no storage. Outputs follow the inputs directly, and the unit can sit between pipeline registers that belong to the surrounding execution stage.

Top module: `simd_cmp_unit`

## Requirements
- R1: `simd_i` selects the lane width with a thermometer code that fills from bit 0. 3'b000 gives 8-bit lanes, 3'b001 gives 16-bit lanes, 3'b011 gives 32-bit lanes and 3'b111 gives one 64-bit lane. Lane k occupies bits [k*W+W-1 : k*W].
- R2: With `op_i` = 3'b000 (mask compare), every bit of a lane of `res_y_o` is 1 when that lane of `opa_i` is less than that lane of `opb_i`. Otherwise every bit of the lane is 0.
- R3: In mask compare, `res_z_o` is all zeros.
- R4: With `op_i` = 3'b011 (min/max), each lane of `res_y_o` carries the smaller of the two lane values and each lane of `res_z_o` carries the larger. When the two lane values are equal, both outputs carry that value.
- R5: With `signed_i` = 1, lane values are two's complement and the sign is the lane's top bit. A lane of `opa_i` with its sign bit set is therefore below a lane of `opb_i` with its sign bit clear. With `signed_i` = 0, lane values are unsigned.
- R6: A lane's result depends only on the operand bits inside that lane. Bits in other lanes have no effect on it.
- R7: Any `op_i` value other than 3'b000 and 3'b011 drives both outputs to all zeros.
- R8: The unit is combinational. A change on any input is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 64 | First operand (A) |
| opb_i | input | 64 | Second operand (B) |
| simd_i | input | 3 | Thermometer lane-width select |
| op_i | input | 3 | Operation select: 000 mask compare, 011 min/max |
| signed_i | input | 1 | 1 = two's-complement lanes, 0 = unsigned |
| res_y_o | output | 64 | Compare mask, or per-lane minimum |
| res_z_o | output | 64 | Zero in compare, or per-lane maximum |

## Verification
The assertions assume that `simd_i` always holds one of the four legal thermometer codes. Their lane-boundary arithmetic reads the width from the count of ones, so a code with a hole in it would make them judge against the wrong lane layout. They also assume that the inputs have settled when they are evaluated. The bench draws `simd_i` only from the four legal codes, built from a granularity index. It mixes random operands with operands that differ in one bit, operands that differ in lane sign bits, equal operands and undefined operation codes.

// File: rtl/simd_cmp_pkg.sv
// Package: shared operation codes for the packed lane compare unit.
// Assumes: op codes not listed here are treated as "no operation" by the unit.
package simd_cmp_pkg;

    typedef enum logic [2:0] {
        OP_MASK_LT = 3'b000,
        OP_MIN_MAX = 3'b011
    } simd_op_e;

    // Number of trailing zeros of a boundary index (its tree level).
    function automatic int boundary_level(input int idx);
        int lvl;
        lvl = 0;
        for (int k = 0; k < 31; k++) begin
            if (((idx >> k) & 1) == 0 && lvl == k) lvl = k + 1;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/simd_cmp_lane_map.sv
// Module: simd_cmp_lane_map
// Turns the thermometer lane-width code into (a) a one-hot selection of the
// combining-tree level that matches the lane width and (b) a flag for every
// segment that sits at the top of its lane (it holds the lane's sign bit).
// Assumes: simd_i is a legal thermometer code filled from bit 0.
module simd_cmp_lane_map #(
    parameter int NSEG = 8,
    parameter int LVL  = 3
) (
    input  logic [LVL-1:0]  simd_i,
    output logic [LVL:0]    lvl_sel_o,
    output logic [NSEG-1:0] seg_top_o
);
    import simd_cmp_pkg::*;

    // Purpose: one-hot level select from the thermometer code.
    always_comb begin
        lvl_sel_o[0]   = ~simd_i[0];
        for (int l = 1; l < LVL; l++) begin
            lvl_sel_o[l] = simd_i[l-1] & ~simd_i[l];
        end
        lvl_sel_o[LVL] = simd_i[LVL-1];
    end

    genvar i;
    generate
        for (i = 0; i < NSEG; i++) begin : g_top
            if (i == NSEG - 1) begin : g_last
                // Purpose: the highest segment always ends a lane.
                assign seg_top_o[i] = 1'b1;
            end else begin : g_inner
                localparam int BLVL = boundary_level(i + 1);
                // Purpose: a boundary is a lane edge unless the width covers it.
                assign seg_top_o[i] = ~simd_i[BLVL];
            end
        end
    endgenerate

endmodule

// File: rtl/simd_cmp_seg_cmp.sv
// Module: simd_cmp_seg_cmp
// Compares one segment of the two operands. When the segment carries the
// sign bit of a signed lane, that bit is inverted on both sides, which maps
// two's-complement order onto unsigned order.
// Assumes: flip_msb_i is only set for the top segment of a signed lane.
module simd_cmp_seg_cmp #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    input  logic             flip_msb_i,
    output logic             lt_o,
    output logic             eq_o
);
    logic [SEG_W-1:0] a_adj;
    logic [SEG_W-1:0] b_adj;

    // Purpose: bias the sign bit for signed lanes.
    always_comb begin
        a_adj = a_i;
        b_adj = b_i;
        a_adj[SEG_W-1] = a_i[SEG_W-1] ^ flip_msb_i;
        b_adj[SEG_W-1] = b_i[SEG_W-1] ^ flip_msb_i;
    end

    // Purpose: segment-local less-than and equality flags.
    always_comb begin
        lt_o = (a_adj < b_adj);
        eq_o = (a_adj == b_adj);
    end

endmodule

// File: rtl/simd_cmp_tree.sv
// Module: simd_cmp_tree
// Merges segment less-than/equal flags into 2x, 4x, ... wider groups. A group
// is "less" if its upper half is less, or if its upper half is equal and its
// lower half is less. Each segment then picks the group result of the level
// that matches the current lane width.
// Assumes: lvl_sel_i is one-hot.
module simd_cmp_tree #(
    parameter int NSEG = 8,
    parameter int LVL  = 3
) (
    input  logic [NSEG-1:0] seg_lt_i,
    input  logic [NSEG-1:0] seg_eq_i,
    input  logic [LVL:0]    lvl_sel_i,
    output logic [NSEG-1:0] lane_lt_o
);
    logic [LVL:0][NSEG-1:0] lt_lv;
    logic [LVL:0][NSEG-1:0] eq_lv;

    // Purpose: build every level of the combining tree.
    always_comb begin
        lt_lv    = '0;
        eq_lv    = '0;
        lt_lv[0] = seg_lt_i;
        eq_lv[0] = seg_eq_i;
        for (int l = 1; l <= LVL; l++) begin
            for (int n = 0; n < (NSEG >> l); n++) begin
                lt_lv[l][n] = lt_lv[l-1][2*n+1]
                            | (eq_lv[l-1][2*n+1] & lt_lv[l-1][2*n]);
                eq_lv[l][n] = eq_lv[l-1][2*n+1] & eq_lv[l-1][2*n];
            end
        end
    end

    // Purpose: each segment takes the result of its own lane.
    always_comb begin
        for (int s = 0; s < NSEG; s++) begin
            lane_lt_o[s] = 1'b0;
            for (int l = 0; l <= LVL; l++) begin
                lane_lt_o[s] = lane_lt_o[s] | (lvl_sel_i[l] & lt_lv[l][s >> l]);
            end
        end
    end

endmodule

// File: rtl/simd_cmp_unit.sv
// Module: simd_cmp_unit (top)
// Combinational packed-lane compare / min-max unit. The operands are split
// into segments; segment flags are merged per lane width, and the lane
// result drives either a mask (compare) or a select (min/max) on each segment.
// Assumes: DATA_W is SEG_W times a power of two of at least 2; simd_i is a
// legal thermometer code.
module simd_cmp_unit #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W,
    localparam int LVL   = $clog2(NSEG)
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [LVL-1:0]    simd_i,
    input  logic [2:0]        op_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] res_y_o,
    output logic [DATA_W-1:0] res_z_o
);
    import simd_cmp_pkg::*;

    logic [LVL:0]    lvl_sel;
    logic [NSEG-1:0] seg_top;
    logic [NSEG-1:0] seg_lt;
    logic [NSEG-1:0] seg_eq;
    logic [NSEG-1:0] lane_lt;

    simd_cmp_lane_map #(.NSEG(NSEG), .LVL(LVL)) u_map (
        .simd_i    (simd_i),
        .lvl_sel_o (lvl_sel),
        .seg_top_o (seg_top)
    );

    genvar s;
    generate
        for (s = 0; s < NSEG; s++) begin : g_seg
            simd_cmp_seg_cmp #(.SEG_W(SEG_W)) u_seg (
                .a_i        (opa_i[s*SEG_W +: SEG_W]),
                .b_i        (opb_i[s*SEG_W +: SEG_W]),
                .flip_msb_i (signed_i & seg_top[s]),
                .lt_o       (seg_lt[s]),
                .eq_o       (seg_eq[s])
            );
        end
    endgenerate

    simd_cmp_tree #(.NSEG(NSEG), .LVL(LVL)) u_tree (
        .seg_lt_i  (seg_lt),
        .seg_eq_i  (seg_eq),
        .lvl_sel_i (lvl_sel),
        .lane_lt_o (lane_lt)
    );

    // Purpose: per-segment output steering by operation.
    always_comb begin
        res_y_o = '0;
        res_z_o = '0;
        for (int k = 0; k < NSEG; k++) begin
            case (op_i)
                OP_MASK_LT: begin
                    res_y_o[k*SEG_W +: SEG_W] = {SEG_W{lane_lt[k]}};
                end
                OP_MIN_MAX: begin
                    res_y_o[k*SEG_W +: SEG_W] = lane_lt[k] ? opa_i[k*SEG_W +: SEG_W]
                                                           : opb_i[k*SEG_W +: SEG_W];
                    res_z_o[k*SEG_W +: SEG_W] = lane_lt[k] ? opb_i[k*SEG_W +: SEG_W]
                                                           : opa_i[k*SEG_W +: SEG_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/simd_cmp_unit_chk.sv
// Module: simd_cmp_unit_chk
// Checker bound to simd_cmp_unit. It checks output shape per operation with
// immediate assertions evaluated whenever the ports change.
// Assumes: simd_i is a legal thermometer code and the inputs have settled.
module simd_cmp_unit_chk #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W,
    localparam int LVL   = $clog2(NSEG)
) (
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [LVL-1:0]    simd_i,
    input logic [2:0]        op_i,
    input logic              signed_i,
    input logic [DATA_W-1:0] res_y_o,
    input logic [DATA_W-1:0] res_z_o
);
    int gran;
    logic [SEG_W-1:0] ys, zs, as, bs;

    // Purpose: derive the lane granularity from the count of ones.
    always_comb gran = $countones(simd_i);

    // Purpose: per-segment and per-lane output shape checks.
    always_comb begin
        for (int k = 0; k < NSEG; k++) begin
            ys = res_y_o[k*SEG_W +: SEG_W];
            zs = res_z_o[k*SEG_W +: SEG_W];
            as = opa_i[k*SEG_W +: SEG_W];
            bs = opb_i[k*SEG_W +: SEG_W];
            if (op_i == 3'b000) begin
                // R2
                mask_shape_chk: assert (ys == '0 || ys == '1)
                    else $error("compare mask segment not uniform");
                // R3
                z_zero_cmp_chk: assert (zs == '0)
                    else $error("Z nonzero in compare");
                if (k < NSEG - 1 && ((k + 1) % (1 << gran)) != 0) begin
                    // R1
                    lane_uniform_chk: assert (ys == res_y_o[(k+1)*SEG_W +: SEG_W])
                        else $error("mask differs inside one lane");
                end
            end else if (op_i == 3'b011) begin
                // R4
                minmax_pair_chk: assert ((ys == as && zs == bs) || (ys == bs && zs == as))
                    else $error("min/max outputs not a permutation of operands");
            end else begin
                // R7
                undef_zero_chk: assert (ys == '0 && zs == '0)
                    else $error("undefined op produced nonzero output");
            end
        end
    end

endmodule

bind simd_cmp_unit simd_cmp_unit_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/simd_cmp_unit_bench.sv
// Bench for simd_cmp_unit: seeded random plus directed vectors, checked
// against a lane-by-lane reference function.
module simd_cmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa, opb, y, z;
    logic [2:0]  simd, op;
    logic        sgn;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    simd_cmp_unit u_simd_cmp_unit (
        .opa_i(opa), .opb_i(opb), .simd_i(simd), .op_i(op),
        .signed_i(sgn), .res_y_o(y), .res_z_o(z)
    );

    function automatic void ref_model(input logic [63:0] a, input logic [63:0] b,
                                      input int g, input logic [2:0] o, input logic s,
                                      output logic [63:0] ey, output logic [63:0] ez);
        int w;
        longint unsigned mask, ua, ub;
        longint sa, sb;
        bit less;
        w = 8 << g;
        ey = '0;
        ez = '0;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        for (int k = 0; k < 64 / w; k++) begin
            ua = (a >> (k * w)) & mask;
            ub = (b >> (k * w)) & mask;
            if (s) begin
                sa = $signed(ua << (64 - w)) >>> (64 - w);
                sb = $signed(ub << (64 - w)) >>> (64 - w);
                less = (sa < sb);
            end else begin
                less = (ua < ub);
            end
            if (o == 3'b000) begin
                if (less) ey = ey | (mask << (k * w));
            end else if (o == 3'b011) begin
                ey = ey | ((less ? ua : ub) << (k * w));
                ez = ez | ((less ? ub : ua) << (k * w));
            end
        end
    endfunction

    task automatic run(input logic [63:0] a, input logic [63:0] b, input int g,
                       input logic [2:0] o, input logic s, input string tag);
        logic [63:0] ey, ez;
        @(posedge clk);
        opa = a; opb = b; simd = 3'((1 << g) - 1); op = o; sgn = s;
        @(negedge clk);
        ref_model(a, b, g, o, s, ey, ez);
        checks++;
        if (y !== ey || z !== ez) begin
            fails++;
            $display("FAIL %s g=%0d op=%b s=%b a=%h b=%h: y=%h z=%h expected y=%h z=%h",
                     tag, g, o, s, a, b, y, z, ey, ez);
        end
    endtask

    initial begin
        opa = '0; opb = '0; simd = '0; op = 3'b000; sgn = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3: idle inputs give a zero mask and zero Z
        checks++;
        if (y !== 64'd0 || z !== 64'd0) begin
            fails++;
            $display("FAIL R2/R3 reset state: y=%h z=%h expected 0 0", y, z);
        end
        void'($urandom(32'h5EED_C0DE));
        for (int g = 0; g < 4; g++) begin
            for (int s = 0; s < 2; s++) begin
                // R4: equal operands
                run(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, g, 3'b011, s[0], "R4 equal");
                run(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, g, 3'b000, s[0], "R2 equal");
                // R5: lane sign bits opposite
                run(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, g, 3'b000, s[0], "R5 sign");
                run(64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080, g, 3'b011, s[0], "R5 sign sort");
                run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, g, 3'b000, s[0], "R5 extremes");
                for (int n = 0; n < 120; n++) begin
                    logic [63:0] a, b;
                    a = {$urandom, $urandom};
                    b = {$urandom, $urandom};
                    run(a, b, g, 3'b000, s[0], "R2 random");
                    run(a, b, g, 3'b011, s[0], "R4 random");
                    // R6: one-bit difference affects only its own lane
                    b = a ^ (64'd1 << $urandom_range(63, 0));
                    run(a, b, g, 3'b000, s[0], "R6 single-bit");
                    run(a, b, g, 3'b011, s[0], "R6 single-bit sort");
                    // R1 R8: same data, other widths come from the loop
                    run(a, {$urandom, $urandom}, g, 3'($urandom_range(7, 0)), s[0], "R7 any op");
                end
            end
            // R7: every undefined code
            for (int o = 0; o < 8; o++) begin
                if (o != 0 && o != 3)
                    run(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, g, 3'(o), 1'b0, "R7 undefined");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule